// File: doc/BRIEF.md
# Two-Flag Predicate and Condition Unit

This unit keeps two single-bit condition flags and decides, for every instruction, whether that instruction is allowed to execute. Each instruction carries a 4-bit predicate nibble: two bits switch checking of each flag on or off, and two bits give the value each checked flag must hold. A flag whose check bit is clear is ignored, so each flag can be ignored, required set, or required clear on its own. The execute-enable output is a purely combinational function of the predicate nibble and the two current flag values.

The flags are written from three sources in the execution stage. A compare operation tests two unsigned operands for equality, greater-than or less-than, and can write the result, optionally inverted, into either flag. An arithmetic operation can write its overflow status into flag 1. A logical operation can write a nonzero-result indication into flag 2. Every write is suppressed when the same instruction's predicate fails. The new flag values appear one clock after the instruction.

Top module: `cond_gate_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, both flags become 0 after that edge.
- R2: When `pred_i[3]` and `pred_i[2]` are both 0, `exec_o` is 1 whatever the flag values.
- R3: When `pred_i[3]` is 1, `exec_o` is 0 unless flag 1 equals `pred_i[1]`.
- R4: When `pred_i[2]` is 1, `exec_o` is 0 unless flag 2 equals `pred_i[0]`; with both checks on, both conditions must hold for `exec_o` to be 1.
- R5: A compare (`cmp_valid_i`) evaluates the unsigned operands by `cmp_op_i[1:0]`: 00 gives a==b, 01 gives a>b, 10 gives a<b; the result lands in the chosen flag after the next rising edge.
- R6: `cmp_op_i[3]` selects the compare destination (0 = flag 1, 1 = flag 2) and `cmp_op_i[2]` = 1 inverts the value written.
- R7: A compare with `cmp_op_i[1:0]` = 11 is reserved and writes no flag.
- R8: `ovf_valid_i` writes `ovf_i` into flag 1 after the next rising edge.
- R9: `nz_valid_i` writes 1 into flag 2 when `nz_data_i` is nonzero and 0 when it is zero.
- R10: When `exec_o` is 0, no source changes either flag.
- R11: When a valid (non-reserved) compare and an overflow or nonzero write target the same flag in one cycle, the compare result is written; writes aimed at different flags both take effect.
- R12: `exec_o` responds in the same cycle as the predicate nibble and flag values, with no register in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pred_i | input | 4 | Predicate nibble: [3] check flag 1, [2] check flag 2, [1] required flag 1, [0] required flag 2 |
| cmp_valid_i | input | 1 | Compare operation present this cycle |
| cmp_op_i | input | 4 | Compare sub-op: [3] destination, [2] invert, [1:0] test kind |
| cmp_a_i | input | 16 | First compare operand (unsigned) |
| cmp_b_i | input | 16 | Second compare operand (unsigned) |
| ovf_valid_i | input | 1 | Arithmetic overflow write strobe |
| ovf_i | input | 1 | Overflow status to write into flag 1 |
| nz_valid_i | input | 1 | Logical nonzero write strobe |
| nz_data_i | input | 16 | Logical result whose nonzero state goes to flag 2 |
| exec_o | output | 1 | Execute enable for the current instruction |
| flag1_o | output | 1 | Current value of flag 1 |
| flag2_o | output | 1 | Current value of flag 2 |

## Verification
The two functions that can fall in one cycle are a compare write and an overflow or nonzero write aimed at the same flag, and either of them colliding with a failing predicate that must block it. The bench provokes this both with directed cycles that assert all three strobes together under passing and failing predicates, and with a long random stream where every strobe is active about half the time. A behavioural model applies the stated priority (predicate gate first, compare over the other sources) and the outcome is judged by comparing both flag outputs to the model after every edge and `exec_o` before every edge.

// File: rtl/cond_pkg.sv
package cond_pkg;

    localparam int NFLAG = 2;

    typedef enum logic [1:0] {
        CMP_EQ  = 2'b00,
        CMP_GT  = 2'b01,
        CMP_LT  = 2'b10,
        CMP_RSV = 2'b11
    } cmp_kind_e;

    typedef struct packed {
        logic      dst;
        logic      inv;
        cmp_kind_e kind;
    } cmp_op_t;

    typedef struct packed {
        logic chk1;
        logic chk2;
        logic want1;
        logic want2;
    } pred_t;

    typedef struct packed {
        logic en;
        logic val;
    } flag_wr_t;

    function automatic logic pred_pass(pred_t p, logic f1, logic f2);
        logic ok1;
        logic ok2;
        ok1 = !p.chk1 || (f1 == p.want1);
        ok2 = !p.chk2 || (f2 == p.want2);
        return ok1 && ok2;
    endfunction

endpackage

// File: rtl/pred_eval.sv
module pred_eval
    import cond_pkg::*;
(
    input  pred_t              pred,
    input  logic [NFLAG-1:0]   flags,
    output logic               pass
);
    always_comb begin
        pass = pred_pass(pred, flags[0], flags[1]);
    end
endmodule

// File: rtl/cmp_unit.sv
module cmp_unit
    import cond_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                   en,
    input  cmp_op_t                op,
    input  logic [W-1:0]           a,
    input  logic [W-1:0]           b,
    output flag_wr_t [NFLAG-1:0]   wr
);
    logic raw;
    logic known;

    always_comb begin
        known = 1'b1;
        unique case (op.kind)
            CMP_EQ:  raw = (a == b);
            CMP_GT:  raw = (a > b);
            CMP_LT:  raw = (a < b);
            default: begin
                raw   = 1'b0;
                known = 1'b0;
            end
        endcase
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_dst
        always_comb begin
            wr[i].en  = en && known && (op.dst == 1'(i));
            wr[i].val = raw ^ op.inv;
        end
    end
endmodule

// File: rtl/flag_store.sv
module flag_store
    import cond_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  flag_wr_t [NFLAG-1:0]   pri_wr,
    input  flag_wr_t [NFLAG-1:0]   sec_wr,
    output logic [NFLAG-1:0]       flag_q
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flag_q[i] <= 1'b0;
            else if (pri_wr[i].en)
                flag_q[i] <= pri_wr[i].val;
            else if (sec_wr[i].en)
                flag_q[i] <= sec_wr[i].val;
        end

        // R11: a primary (compare) write is never overridden by a secondary one
        a_r11_pri_wins: assert property (@(posedge clk) disable iff (rst)
            pri_wr[i].en |=> (flag_q[i] == $past(pri_wr[i].val)));
    end

    // R1: reset clears both flags
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (flag_q == '0));
endmodule

// File: rtl/cond_gate_unit.sv
module cond_gate_unit
    import cond_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [3:0]   pred_i,
    input  logic         cmp_valid_i,
    input  logic [3:0]   cmp_op_i,
    input  logic [W-1:0] cmp_a_i,
    input  logic [W-1:0] cmp_b_i,
    input  logic         ovf_valid_i,
    input  logic         ovf_i,
    input  logic         nz_valid_i,
    input  logic [W-1:0] nz_data_i,
    output logic         exec_o,
    output logic         flag1_o,
    output logic         flag2_o
);
    localparam int F1 = 0;
    localparam int F2 = 1;

    pred_t               pred;
    cmp_op_t             op;
    logic [NFLAG-1:0]    flags;
    logic                pass;
    flag_wr_t [NFLAG-1:0] cmp_wr;
    flag_wr_t [NFLAG-1:0] side_wr;

    assign pred = pred_t'(pred_i);
    assign op   = cmp_op_t'(cmp_op_i);

    pred_eval u_pred (
        .pred  (pred),
        .flags (flags),
        .pass  (pass)
    );

    cmp_unit #(.W(W)) u_cmp (
        .en (pass && cmp_valid_i),
        .op (op),
        .a  (cmp_a_i),
        .b  (cmp_b_i),
        .wr (cmp_wr)
    );

    always_comb begin
        side_wr[F1].en  = pass && ovf_valid_i;
        side_wr[F1].val = ovf_i;
        side_wr[F2].en  = pass && nz_valid_i;
        side_wr[F2].val = |nz_data_i;
    end

    flag_store u_store (
        .clk    (clk),
        .rst    (rst),
        .pri_wr (cmp_wr),
        .sec_wr (side_wr),
        .flag_q (flags)
    );

    assign exec_o  = pass;
    assign flag1_o = flags[F1];
    assign flag2_o = flags[F2];

    // R2: no check bits set means unconditional execution
    a_r2_uncond: assert property (@(posedge clk) disable iff (rst)
        (pred_i[3:2] == 2'b00) |-> exec_o);

    // R3: flag 1 mismatch with an active check blocks execution
    a_r3_flag1_block: assert property (@(posedge clk) disable iff (rst)
        (pred_i[3] && (flag1_o != pred_i[1])) |-> !exec_o);

    // R10: a blocked instruction leaves both flags untouched
    a_r10_blocked_hold: assert property (@(posedge clk) disable iff (rst)
        !exec_o |=> $stable({flag1_o, flag2_o}));

    // R7: a reserved compare alone changes nothing
    a_r7_reserved: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid_i && cmp_op_i[1:0] == 2'b11 && !ovf_valid_i && !nz_valid_i)
            |=> $stable({flag1_o, flag2_o}));

    // R8: overflow write reaches flag 1 when no compare targets it
    a_r8_ovf_write: assert property (@(posedge clk) disable iff (rst)
        (exec_o && ovf_valid_i &&
         !(cmp_valid_i && cmp_op_i[1:0] != 2'b11 && !cmp_op_i[3]))
            |=> (flag1_o == $past(ovf_i)));
endmodule

// File: tb/cond_gate_unit_tb.sv
module cond_gate_unit_tb_top;
    localparam int W = 16;
    localparam time CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic [3:0]   pred_i;
    logic         cmp_valid_i;
    logic [3:0]   cmp_op_i;
    logic [W-1:0] cmp_a_i, cmp_b_i;
    logic         ovf_valid_i, ovf_i;
    logic         nz_valid_i;
    logic [W-1:0] nz_data_i;
    logic         exec_o, flag1_o, flag2_o;

    int total = 0;
    int bad   = 0;
    int m1 = 0;
    int m2 = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cond_gate_unit #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .pred_i(pred_i),
        .cmp_valid_i(cmp_valid_i), .cmp_op_i(cmp_op_i),
        .cmp_a_i(cmp_a_i), .cmp_b_i(cmp_b_i),
        .ovf_valid_i(ovf_valid_i), .ovf_i(ovf_i),
        .nz_valid_i(nz_valid_i), .nz_data_i(nz_data_i),
        .exec_o(exec_o), .flag1_o(flag1_o), .flag2_o(flag2_o)
    );

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one instruction at the falling edge, check exec before the
    // rising edge, advance the model, check flags after the edge.
    task automatic step(input logic [3:0] p, input logic cv, input logic [3:0] op,
                        input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic ov_v, input logic ov, input logic nv,
                        input logic [W-1:0] nd, input string tag);
        int ex;
        int n1;
        int n2;
        int r;
        @(negedge clk);
        pred_i = p; cmp_valid_i = cv; cmp_op_i = op; cmp_a_i = a; cmp_b_i = b;
        ovf_valid_i = ov_v; ovf_i = ov; nz_valid_i = nv; nz_data_i = nd;
        #1;
        ex = ((!p[3] || m1 == int'(p[1])) && (!p[2] || m2 == int'(p[0]))) ? 1 : 0;
        if (p[3:2] == 2'b00) check({tag, " R2 exec"}, int'(exec_o), ex);
        else if (p[3] && p[2]) check({tag, " R4 exec"}, int'(exec_o), ex);
        else if (p[3]) check({tag, " R3 exec"}, int'(exec_o), ex);
        else check({tag, " R4 exec"}, int'(exec_o), ex);
        n1 = m1; n2 = m2;
        if (ex == 1) begin
            if (nv) n2 = (nd != 0) ? 1 : 0;
            if (ov_v) n1 = int'(ov);
            if (cv && op[1:0] != 2'b11) begin
                if (op[1:0] == 2'b00) r = (a == b) ? 1 : 0;
                else if (op[1:0] == 2'b01) r = (a > b) ? 1 : 0;
                else r = (a < b) ? 1 : 0;
                if (op[2]) r = 1 - r;
                if (op[3]) n2 = r; else n1 = r;
            end
        end
        m1 = n1; m2 = n2;
        @(posedge clk);
        #1;
        check({tag, " flag1"}, int'(flag1_o), m1);
        check({tag, " flag2"}, int'(flag2_o), m2);
    endtask

    task automatic idle(input logic [3:0] p, input string tag);
        step(p, 1'b0, 4'h0, '0, '0, 1'b0, 1'b0, 1'b0, '0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        pred_i = 4'h0; cmp_valid_i = 0; cmp_op_i = 0; cmp_a_i = 0; cmp_b_i = 0;
        ovf_valid_i = 0; ovf_i = 0; nz_valid_i = 0; nz_data_i = 0;
        // drive a flag-setting op during reset: must not stick
        ovf_valid_i = 1; ovf_i = 1; nz_valid_i = 1; nz_data_i = 16'h1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset flag1", int'(flag1_o), 0);
        check("R1 reset flag2", int'(flag2_o), 0);
        @(negedge clk);
        rst = 1'b0;
        pred_i = 4'b1100; #1;
        check("R1 R4 exec want 0,0 after reset", int'(exec_o), 1);
        pred_i = 4'b1110; #1;
        check("R3 exec want flag1=1 after reset", int'(exec_o), 0);

        // R5 R6: compare kinds, destinations and inversion (unsigned)
        step(4'b0000, 1, 4'b0000, 16'h1234, 16'h1234, 0, 0, 0, '0, "R5 eq->f1");
        step(4'b0000, 1, 4'b1001, 16'h8000, 16'h0001, 0, 0, 0, '0, "R5 gt unsigned->f2");
        step(4'b0000, 1, 4'b0010, 16'h8000, 16'h0001, 0, 0, 0, '0, "R5 lt unsigned->f1");
        step(4'b0000, 1, 4'b0100, 16'h0005, 16'h0006, 0, 0, 0, '0, "R6 inv eq->f1");
        step(4'b0000, 1, 4'b1110, 16'h0007, 16'h0007, 0, 0, 0, '0, "R6 inv lt->f2");
        // R7: reserved kind touches nothing
        step(4'b0000, 1, 4'b0011, 16'h0001, 16'h0002, 0, 0, 0, '0, "R7 reserved f1");
        step(4'b0000, 1, 4'b1111, 16'h0001, 16'h0002, 0, 0, 0, '0, "R7 reserved f2");
        // R8 R9
        step(4'b0000, 0, 4'h0, '0, '0, 1, 0, 0, '0, "R8 ovf clear");
        step(4'b0000, 0, 4'h0, '0, '0, 1, 1, 0, '0, "R8 ovf set");
        step(4'b0000, 0, 4'h0, '0, '0, 0, 0, 1, 16'h0000, "R9 zero");
        step(4'b0000, 0, 4'h0, '0, '0, 0, 0, 1, 16'h8000, "R9 nonzero");
        // R3 R4 predicate combinations over all four flag states
        for (int s = 0; s < 4; s++) begin
            step(4'b0000, 0, 4'h0, '0, '0, 1, s[0], 1, W'(s[1]), "setup");
            for (int p = 0; p < 16; p++) idle(4'(p), "R3 R4 table");
        end
        // R10: blocked instruction with every strobe active
        step(4'b0000, 0, 4'h0, '0, '0, 1, 0, 1, 16'h0, "setup");
        step(4'b1010, 1, 4'b0000, 16'h3, 16'h3, 1, 1, 1, 16'h9, "R10 blocked f1");
        step(4'b0101, 1, 4'b1000, 16'h3, 16'h3, 1, 1, 1, 16'h9, "R10 blocked f2");
        // R11: same-flag collisions and split targets
        step(4'b0000, 1, 4'b0000, 16'h1, 16'h2, 1, 1, 0, '0, "R11 cmp over ovf");
        step(4'b0000, 1, 4'b1000, 16'h1, 16'h2, 0, 0, 1, 16'h4, "R11 cmp over nz");
        step(4'b0000, 1, 4'b1000, 16'h2, 16'h2, 1, 0, 1, 16'h0, "R11 split targets");
        step(4'b0000, 1, 4'b0011, 16'h2, 16'h2, 1, 1, 1, 16'h0, "R11 R7 reserved yields");
        // R12 and everything: random stream
        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] a;
            logic [W-1:0] b;
            a = W'($urandom);
            b = ($urandom % 4 == 0) ? a : W'($urandom);
            step(4'($urandom), 1'($urandom), 4'($urandom), a, b,
                 1'($urandom), 1'($urandom), 1'($urandom),
                 ($urandom % 3 == 0) ? '0 : W'($urandom), "R12 random");
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule